// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block holds the two 32-bit product and quotient registers, HI and LO, of a pipelined integer core. The pipeline presents a one-cycle `start` pulse with a 6-bit function code and two operands. Four codes start an iterative arithmetic operation: a signed or unsigned multiply that produces a 64-bit product, or a signed or unsigned divide that produces a quotient and a remainder. Four more codes move a value between a general register and HI or LO.

The arithmetic runs one bit per cycle. During that time `busy` stays high. A read of HI or LO is accepted only while `busy` is low, so the pipeline stalls a read that arrives too early until the unit is idle. A move into HI or LO cancels any operation in progress. A new arithmetic command that arrives during an operation replaces it.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, `busy` is 0 and both HI and LO read as zero.
- R2: Function code 011000 multiplies the operands as signed two's-complement values and 011001 multiplies them as unsigned values. The upper half of the 64-bit product goes to HI and the lower half goes to LO.
- R3: Function code 011010 divides signed and 011011 divides unsigned. The quotient goes to LO and the remainder goes to HI. A signed quotient is truncated toward zero, and the remainder carries the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R4: Dividing by zero completes with no fault. LO is then all ones and HI equals the dividend, for both signed and unsigned division.
- R5: An accepted multiply or divide raises `busy` on the next clock edge. `busy` stays high for exactly W cycles (32 by default). HI and LO hold their new values from the cycle in which `busy` falls.
- R6: Code 010000 reads HI and code 010010 reads LO on `rd_data`. `rd_valid` is high only when such a read is presented while `busy` is low.
- R7: Code 010001 loads `op_a` into HI and code 010011 loads `op_a` into LO. The other register is not changed.
- R8: A load of HI or LO while `busy` is high cancels the running operation. `busy` is low on the next cycle, and the register that was not loaded keeps the value it had before the operation started.
- R9: A multiply or divide command issued while `busy` is high restarts the unit with the new operands. The full W-cycle latency is counted from the new command.
- R10: A `start` with any function code not listed above does not change HI, LO or `busy`.
- R11: HI and LO do not change while an operation is running, except at its final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Command strobe, one cycle per command |
| func | input | 6 | Function code of the command |
| op_a | input | 32 | First operand: multiplicand, dividend, or value to load into HI or LO |
| op_b | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while a multiply or divide is in progress |
| rd_valid | output | 1 | A HI or LO read is accepted this cycle |
| rd_data | output | 32 | HI or LO, selected by the read function code |

## Verification
Properties in the bound checker cover the timing rules on every cycle:
- `busy` rises after each accepted arithmetic command.
- `busy` falls exactly W cycles after that command, unless a load of HI or LO cut the operation short.
- A load aborts the operation on the next edge and changes only its own register.
- HI and LO stay frozen when the unit is idle and during every cycle of an operation except the last.

The numerical results can only be shown by the bench's scenarios, which compare them against reference arithmetic. These include signed multiplies and divides with mixed signs, the most negative value, division by zero, a restart partway through an operation, and a read rejected while `busy` is high.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [5:0] {
    FN_MFHI  = 6'b010000,
    FN_MTHI  = 6'b010001,
    FN_MFLO  = 6'b010010,
    FN_MTLO  = 6'b010011,
    FN_MULT  = 6'b011000,
    FN_MULTU = 6'b011001,
    FN_DIV   = 6'b011010,
    FN_DIVU  = 6'b011011
  } mdu_fn_e;

  typedef enum logic {
    KIND_MUL = 1'b0,
    KIND_DIV = 1'b1
  } mdu_kind_e;

endpackage

// File: rtl/mdu_cond_neg.sv
module mdu_cond_neg #(
  parameter int W = 32
) (
  input  logic         neg_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);

  // Two's-complement negate when requested; pass through otherwise.
  always_comb begin
    if (neg_i) val_o = (~val_i) + W'(1);
    else       val_o = val_i;
  end

endmodule

// File: rtl/mdu_mult_core.sv
module mdu_mult_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0] mcand_q;
  logic [W-1:0] upper_q, upper_d;
  logic [W-1:0] lower_q, lower_d;
  logic [W:0]   partial;

  // One shift-add step: add the multiplicand into the upper half when the
  // current multiplier bit is set, then shift the whole pair right by one.
  always_comb begin
    partial = {1'b0, upper_q} + (lower_q[0] ? {1'b0, mcand_q} : '0);
    upper_d = partial[W:1];
    lower_d = {partial[0], lower_q[W-1:1]};
  end

  assign prod_o = {upper_d, lower_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      upper_q <= '0;
      lower_q <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      upper_q <= '0;
      lower_q <= b_i;
    end else if (step_i) begin
      upper_q <= upper_d;
      lower_q <= lower_d;
    end
  end

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] dvs_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W:0]   shifted;
  logic [W+1:0] diff;
  logic         fits;

  // One restoring step: bring in the next dividend bit, try to subtract the
  // divisor, keep the difference when it did not borrow.
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~diff[W+1];
    rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      dvs_q <= dvs_i;
      rem_q <= '0;
      quo_q <= dvd_i;
    end else if (step_i) begin
      rem_q <= rem_o;
      quo_q <= quo_o;
    end
  end

endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   func,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);

  localparam int CNT_W = $clog2(W + 1);
  localparam int PW    = 2 * W;

  // ---------------------------------------------------------------- reset
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // --------------------------------------------------------------- decode
  logic is_mul, is_div, is_signed, is_mthi, is_mtlo, is_mf;
  logic go_arith, go_mt_hi, go_mt_lo, go_mt;

  always_comb begin
    is_mul    = (func == FN_MULT) || (func == FN_MULTU);
    is_div    = (func == FN_DIV)  || (func == FN_DIVU);
    is_signed = (func == FN_MULT) || (func == FN_DIV);
    is_mthi   = (func == FN_MTHI);
    is_mtlo   = (func == FN_MTLO);
    is_mf     = (func == FN_MFHI) || (func == FN_MFLO);
    go_arith  = start && (is_mul || is_div);
    go_mt_hi  = start && is_mthi;
    go_mt_lo  = start && is_mtlo;
    go_mt     = go_mt_hi || go_mt_lo;
  end

  // ------------------------------------------------- operand magnitudes
  logic [W-1:0] opnd     [2];
  logic [W-1:0] opnd_mag [2];
  logic [1:0]   opnd_neg;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_mag
    assign opnd_neg[gi] = is_signed && opnd[gi][W-1];
    mdu_cond_neg #(.W(W)) u_mag (
      .neg_i (opnd_neg[gi]),
      .val_i (opnd[gi]),
      .val_o (opnd_mag[gi])
    );
  end

  // ------------------------------------------------------------ control
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mdu_kind_e        kind_q, kind_d;
  logic             neg_res_q, neg_res_d;
  logic             neg_rem_q, neg_rem_d;
  logic             dz_q, dz_d;
  logic             last, done_evt;

  assign last     = busy_q && (cnt_q == CNT_W'(1));
  assign done_evt = last && !go_arith && !go_mt;

  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    kind_d    = kind_q;
    neg_res_d = neg_res_q;
    neg_rem_d = neg_rem_q;
    dz_d      = dz_q;
    if (go_arith) begin
      busy_d    = 1'b1;
      cnt_d     = CNT_W'(W);
      kind_d    = is_div ? KIND_DIV : KIND_MUL;
      neg_res_d = opnd_neg[0] ^ opnd_neg[1];
      neg_rem_d = opnd_neg[0];
      dz_d      = (op_b == '0);
    end else if (go_mt) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      kind_q    <= KIND_MUL;
      neg_res_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      kind_q    <= kind_d;
      neg_res_q <= neg_res_d;
      neg_rem_q <= neg_rem_d;
      dz_q      <= dz_d;
    end
  end

  // -------------------------------------------------------- datapaths
  logic [PW-1:0] prod_raw, prod_fix;
  logic [W-1:0]  quo_raw, quo_fix, rem_raw, rem_fix;

  mdu_mult_core #(.W(W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (go_arith && is_mul),
    .step_i (busy_q),
    .a_i    (opnd_mag[0]),
    .b_i    (opnd_mag[1]),
    .prod_o (prod_raw)
  );

  mdu_div_core #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (go_arith && is_div),
    .step_i (busy_q),
    .dvd_i  (opnd_mag[0]),
    .dvs_i  (opnd_mag[1]),
    .quo_o  (quo_raw),
    .rem_o  (rem_raw)
  );

  mdu_cond_neg #(.W(PW)) u_prod_fix (
    .neg_i (neg_res_q),
    .val_i (prod_raw),
    .val_o (prod_fix)
  );

  mdu_cond_neg #(.W(W)) u_quo_fix (
    .neg_i (neg_res_q),
    .val_i (quo_raw),
    .val_o (quo_fix)
  );

  mdu_cond_neg #(.W(W)) u_rem_fix (
    .neg_i (neg_rem_q),
    .val_i (rem_raw),
    .val_o (rem_fix)
  );

  // ------------------------------------------------------- HI / LO
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_en, lo_en;

  always_comb begin
    hi_en = go_mt_hi || done_evt;
    lo_en = go_mt_lo || done_evt;
    if (go_mt_hi)                hi_d = op_a;
    else if (kind_q == KIND_MUL) hi_d = prod_fix[PW-1:W];
    else                         hi_d = rem_fix;
    if (go_mt_lo)                lo_d = op_a;
    else if (kind_q == KIND_MUL) lo_d = prod_fix[W-1:0];
    else if (dz_q)               lo_d = '1;
    else                         lo_d = quo_fix;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  // ---------------------------------------------------------- outputs
  assign busy     = busy_q;
  assign rd_valid = start && is_mf && !busy_q;
  assign rd_data  = (func == FN_MFHI) ? hi_q : lo_q;

endmodule

// File: rtl/hilo_mdu_chk.sv
module hilo_mdu_chk
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [5:0]   func,
  input logic [W-1:0] op_a,
  input logic         busy,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);

  localparam int CW = $clog2(W + 1) + 1;

  logic          arith_go, mt_go, mthi_go;
  logic [CW-1:0] cyc_q;

  assign arith_go = start && ((func == FN_MULT) || (func == FN_MULTU) ||
                              (func == FN_DIV)  || (func == FN_DIVU));
  assign mthi_go  = start && (func == FN_MTHI);
  assign mt_go    = mthi_go || (start && (func == FN_MTLO));

  // Cycles elapsed since the last accepted arithmetic command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cyc_q <= '0;
    else if (arith_go)                        cyc_q <= '0;
    else if (busy && (cyc_q != {CW{1'b1}}))   cyc_q <= cyc_q + CW'(1);
  end

  // R5
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith_go |=> busy);

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(mt_go)) |-> (cyc_q == CW'(W)));

  // R8
  move_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mt_go |=> !busy);

  // R7
  move_hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mthi_go |=> ((hi_q == $past(op_a)) && (lo_q == $past(lo_q))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi_q) && $stable(lo_q)));

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && (cyc_q != CW'(W - 1))) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind hilo_mdu hilo_mdu_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .start (start),
  .func  (func),
  .op_a  (op_a),
  .busy  (busy),
  .hi_q  (hi_q),
  .lo_q  (lo_q)
);

// File: tb/hilo_mdu_tb.sv
module hilo_mdu_tb;

  localparam int W = 32;
  localparam logic [5:0] F_MFHI = 6'b010000, F_MTHI = 6'b010001,
                         F_MFLO = 6'b010010, F_MTLO = 6'b010011,
                         F_MULT = 6'b011000, F_MULTU = 6'b011001,
                         F_DIV  = 6'b011010, F_DIVU = 6'b011011,
                         F_NONE = 6'b100000;

  logic         clk, rst_n, start, busy, rd_valid;
  logic [5:0]   func;
  logic [W-1:0] op_a, op_b, rd_data;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  hilo_mdu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func),
    .op_a(op_a), .op_b(op_b), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] ref_res(input logic [5:0] f,
                                          input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, p;
    logic [63:0] u;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      F_MULT:  begin p = sa * sb; return p; end
      F_MULTU: begin u = {32'd0, a} * {32'd0, b}; return u; end
      F_DIV:   if (b == 0) return {a, 32'hFFFF_FFFF};
               else return {32'(sa % sb), 32'(sa / sb)};
      F_DIVU:  if (b == 0) return {a, 32'hFFFF_FFFF};
               else return {a % b, a / b};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; func = f; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; func = F_NONE;
  endtask

  // Counts negedges with busy high, starting at the current negedge.
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Reads HI and LO between edges; no clock edge is crossed.
  task automatic read_hilo(output logic [31:0] hi, output logic [31:0] lo, output logic vld);
    logic v0, v1;
    start = 1'b1; func = F_MFHI; #1;
    v0 = rd_valid; hi = rd_data;
    func = F_MFLO; #1;
    v1 = rd_valid; lo = rd_data;
    start = 1'b0; func = F_NONE;
    vld = v0 & v1;
  endtask

  task automatic run_arith(input logic [5:0] f, input logic [31:0] a,
                           input logic [31:0] b, input string tag);
    int n;
    logic [31:0] hi, lo;
    logic vld;
    issue(f, a, b);
    wait_idle(n);
    check("R5 latency", 64'(n), 64'(W));
    read_hilo(hi, lo, vld);
    check("R6 read valid when idle", 64'(vld), 64'd1);
    check(tag, {hi, lo}, ref_res(f, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hi, lo, hi0, lo0, a, b;
    logic vld;
    int n;
    logic [5:0] fsel [4];
    fsel[0] = F_MULT; fsel[1] = F_MULTU; fsel[2] = F_DIV; fsel[3] = F_DIVU;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; func = F_NONE; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy after reset", 64'(busy), 64'd0);
    read_hilo(hi, lo, vld);
    check("R1 HI/LO after reset", {hi, lo}, 64'd0);

    // R2 directed multiplies
    run_arith(F_MULT,  32'h8000_0000, 32'h8000_0000, "R2 mult min*min");
    run_arith(F_MULT,  32'h8000_0000, 32'hFFFF_FFFF, "R2 mult min*-1");
    run_arith(F_MULT,  32'hFFFF_FFF9, 32'd6,         "R2 mult -7*6");
    run_arith(F_MULTU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 multu max*max");
    // R3 directed divides
    run_arith(F_DIV,   32'h8000_0000, 32'hFFFF_FFFF, "R3 div min/-1");
    run_arith(F_DIV,   32'd7,         32'hFFFF_FFFE, "R3 div 7/-2");
    run_arith(F_DIV,   32'hFFFF_FFF9, 32'd2,         "R3 div -7/2");
    run_arith(F_DIVU,  32'hFFFF_FFFF, 32'd1,         "R3 divu max/1");
    // R4 division by zero
    run_arith(F_DIV,   32'hFFFF_FFFB, 32'd0,         "R4 div -5/0");
    run_arith(F_DIVU,  32'h0000_1234, 32'd0,         "R4 divu x/0");

    // random mix
    for (int i = 0; i < 48; i++) begin
      logic [5:0] f;
      f = fsel[$urandom_range(0, 3)];
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 3) == 0) b = 32'($urandom_range(0, 9)) - 32'd4;
      if ($urandom_range(0, 5) == 0) a = 32'h8000_0000;
      run_arith(f, a, b, (f == F_MULT || f == F_MULTU) ? "R2 random" : "R3 random");
    end

    // R6 read rejected while busy; result still correct
    issue(F_MULT, 32'h1234_5678, 32'hFEDC_BA98);
    start = 1'b1; func = F_MFHI; #1;
    check("R6 read stalled while busy", 64'(rd_valid), 64'd0);
    start = 1'b0; func = F_NONE;
    wait_idle(n);
    read_hilo(hi, lo, vld);
    check("R2 result after stalled read", {hi, lo}, ref_res(F_MULT, 32'h1234_5678, 32'hFEDC_BA98));
    hi0 = hi; lo0 = lo;

    // R8 / R11 abort by load of HI mid-divide
    issue(F_DIV, 32'd1000, 32'd7);
    repeat (5) @(negedge clk);
    issue(F_MTHI, 32'hCAFE_0001, 32'd0);
    check("R8 busy cleared after abort", 64'(busy), 64'd0);
    read_hilo(hi, lo, vld);
    check("R7 HI loaded", 64'(hi), 64'hCAFE_0001);
    check("R8 R11 LO kept pre-op value", 64'(lo), 64'(lo0));

    // R7 load LO while idle
    issue(F_MTLO, 32'hBEEF_0002, 32'd0);
    read_hilo(hi, lo, vld);
    check("R7 MTLO writes LO only", {hi, lo}, {32'hCAFE_0001, 32'hBEEF_0002});

    // R10 unknown function code
    issue(F_NONE, 32'hDEAD_DEAD, 32'h1);
    check("R10 busy unchanged", 64'(busy), 64'd0);
    read_hilo(hi, lo, vld);
    check("R10 HI/LO unchanged", {hi, lo}, {32'hCAFE_0001, 32'hBEEF_0002});

    // R9 restart mid-operation
    issue(F_DIV, 32'd99, 32'd5);
    repeat (3) @(negedge clk);
    issue(F_MULTU, 32'h0001_0003, 32'h0002_0005);
    wait_idle(n);
    check("R9 latency after restart", 64'(n), 64'(W));
    read_hilo(hi, lo, vld);
    check("R9 restarted result", {hi, lo}, ref_res(F_MULTU, 32'h0001_0003, 32'h0002_0005));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule